// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers eight maskable interrupt sources for an 8-bit microcontroller core and turns them into one request line and one vector address. The sources are two external pins, two timers, an A/D converter, a watchdog, an interval timer and an SPI unit. A one-cycle event pulse from a source latches into that source's request flag. A flag is pending when its enable bit is set. The core sees a request when at least one source is pending and the global interrupt enable is on.

Software reaches two enable registers and two request-flag registers over a byte-wide register bus. Reads are combinational on the address. When the core acknowledges, the controller captures the vector of the highest-priority pending source and turns off the global enable, so no second interrupt can nest. The controller never clears request flags. The service routine polls them and clears them by writing, before it turns the global enable back on.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset all four registers read 0x00, `gie_o` is 0, `irq_req` is 0 and `irq_vec` is 0x0000.
- R2: Enable bits sit in the upper nibble at addresses 0xE2 (bit 7..4 = sources 0..3) and 0xE3 (bit 7..4 = sources 4..7). Request flags use the same layout at 0xE4 and 0xE5. Bits 3..0 of every register read 0, and writes to them have no effect.
- R3: An event pulse on `src_evt[i]` sets flag i at the next clock edge. Software can read each flag and can write it to 0 or to 1.
- R4: If a register write of 0 and an event for the same flag arrive in the same cycle, the flag ends up 1.
- R5: `irq_req` is 1 exactly when `gie_o` is 1 and some source has both its flag and its enable set. A source whose enable bit is 0 never raises `irq_req`.
- R6: Priority is fixed by source index, with 0 highest and 7 lowest. The order is INT0, INT1, timer 0, timer 1, A/D, watchdog, interval timer, SPI.
- R7: On a clock edge where `ack` and `irq_req` are both 1, `irq_vec` takes 0xFFFA − 2·index of the winning source, so INT0 gets 0xFFFA and SPI gets 0xFFEC. At every other edge `irq_vec` holds its value.
- R8: An `ack` clears `gie_o` at the edge that samples it. If `gie_we` is asserted in the same cycle, the `ack` takes precedence.
- R9: Acknowledging an interrupt leaves every request flag unchanged.
- R10: When `gie_we` is 1 and `ack` is 0, `gie_o` takes `gie_wd` at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Register address |
| bus_we | input | 1 | Register write strobe |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data, combinational on `bus_addr` |
| src_evt | input | 8 | Per-source event pulses, index = priority |
| gie_we | input | 1 | Write strobe for the global enable |
| gie_wd | input | 1 | New value of the global enable |
| gie_o | output | 1 | Global interrupt enable (status word bit 2) |
| ack | input | 1 | One-cycle acknowledge from the core |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vec | output | 16 | Vector captured at the last accepted acknowledge |

## Verification
The bench pulses two sources at once and checks that the vector belongs to the lower index. Inverting the priority scan would return the watchdog vector instead of the timer vector. It then disables the winner and acknowledges again, which exposes a design that arbitrates on raw flags instead of on pending sources. It checks that the flags survive an acknowledge, because a controller that auto-clears them would read back zero. It also drives a flag-clearing write in the same cycle as an event. A design that gives the write priority would lose the event.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
   localparam int unsigned IRQC_NSRC   = 8;
   localparam int unsigned IRQC_DATA_W = 8;
   localparam int unsigned IRQC_VEC_W  = 16;

   typedef enum logic [1:0] {
      RSEL_EN_HI = 2'd0,
      RSEL_EN_LO = 2'd1,
      RSEL_FL_HI = 2'd2,
      RSEL_FL_LO = 2'd3
   } rsel_e;
endpackage

// File: rtl/irqc_src_cell.sv
module irqc_src_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic en_we,
   input  logic en_wd,
   input  logic fl_we,
   input  logic fl_wd,
   input  logic evt,
   output logic en_q,
   output logic fl_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q <= 1'b0;
      end else if (en_we) begin
         en_q <= en_wd;
      end
   end

   // event has precedence over a software write in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fl_q <= 1'b0;
      end else if (evt) begin
         fl_q <= 1'b1;
      end else if (fl_we) begin
         fl_q <= fl_wd;
      end
   end
endmodule

// File: rtl/irqc_prio_enc.sv
module irqc_prio_enc #(
   parameter int unsigned NSRC      = 8,
   parameter bit          LOW_FIRST = 1'b1,
   localparam int unsigned IDX_W    = (NSRC > 1) ? $clog2(NSRC) : 1
) (
   input  logic [NSRC-1:0]  pend,
   output logic             any,
   output logic [IDX_W-1:0] idx
);
   initial begin
      if (NSRC < 2) $error("irqc_prio_enc: NSRC must be at least 2");
   end

   assign any = |pend;

   generate
      if (LOW_FIRST) begin : g_low
         always_comb begin
            idx = '0;
            for (int i = NSRC - 1; i >= 0; i--) begin
               if (pend[i]) idx = IDX_W'(i);
            end
         end
      end else begin : g_high
         always_comb begin
            idx = '0;
            for (int i = 0; i < NSRC; i++) begin
               if (pend[i]) idx = IDX_W'(i);
            end
         end
      end
   endgenerate
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
   import irqc_pkg::*;
#(
   parameter int unsigned NSRC       = IRQC_NSRC,
   parameter int unsigned DATA_W     = IRQC_DATA_W,
   parameter int unsigned ADDR_W     = 8,
   parameter int unsigned VEC_W      = IRQC_VEC_W,
   parameter logic [VEC_W-1:0] VEC_TOP = 16'hFFFA,
   parameter int unsigned VEC_STEP   = 2,
   parameter logic [ADDR_W-1:0] EN_HI_ADDR = 8'hE2,
   parameter logic [ADDR_W-1:0] EN_LO_ADDR = 8'hE3,
   parameter logic [ADDR_W-1:0] FL_HI_ADDR = 8'hE4,
   parameter logic [ADDR_W-1:0] FL_LO_ADDR = 8'hE5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [NSRC-1:0]   src_evt,
   input  logic              gie_we,
   input  logic              gie_wd,
   output logic              gie_o,
   input  logic              ack,
   output logic              irq_req,
   output logic [VEC_W-1:0]  irq_vec
);
   localparam int unsigned HALF  = NSRC / 2;
   localparam int unsigned IDX_W = $clog2(NSRC);
   localparam int unsigned LOW_W = DATA_W - HALF;

   initial begin
      if (NSRC % 2 != 0)    $error("irq_vec_ctrl: NSRC must be even");
      if (HALF >= DATA_W)   $error("irq_vec_ctrl: half of NSRC must fit below DATA_W");
      if (VEC_STEP * NSRC >= 2 ** VEC_W) $error("irq_vec_ctrl: vector table overflows");
   end

   // ---------------- address decode ----------------
   logic  hit_en_hi, hit_en_lo, hit_fl_hi, hit_fl_lo;
   rsel_e rsel;
   logic  rhit;

   assign hit_en_hi = (bus_addr == EN_HI_ADDR);
   assign hit_en_lo = (bus_addr == EN_LO_ADDR);
   assign hit_fl_hi = (bus_addr == FL_HI_ADDR);
   assign hit_fl_lo = (bus_addr == FL_LO_ADDR);

   always_comb begin
      rsel = RSEL_EN_HI;
      rhit = 1'b1;
      if      (hit_en_hi) rsel = RSEL_EN_HI;
      else if (hit_en_lo) rsel = RSEL_EN_LO;
      else if (hit_fl_hi) rsel = RSEL_FL_HI;
      else if (hit_fl_lo) rsel = RSEL_FL_LO;
      else                rhit = 1'b0;
   end

   // ---------------- per-source state ----------------
   logic [NSRC-1:0] en_q;
   logic [NSRC-1:0] fl_q;

   generate
      for (genvar i = 0; i < NSRC; i++) begin : g_src
         localparam int unsigned POS = (i < HALF) ? (DATA_W - 1 - i)
                                                  : (DATA_W - 1 - (i - HALF));
         logic en_sel, fl_sel;
         if (i < HALF) begin : g_hi
            assign en_sel = hit_en_hi;
            assign fl_sel = hit_fl_hi;
         end else begin : g_lo
            assign en_sel = hit_en_lo;
            assign fl_sel = hit_fl_lo;
         end
         irqc_src_cell cell_i (
            .clk   (clk),
            .rst_n (rst_n),
            .en_we (bus_we & en_sel),
            .en_wd (bus_wdata[POS]),
            .fl_we (bus_we & fl_sel),
            .fl_wd (bus_wdata[POS]),
            .evt   (src_evt[i]),
            .en_q  (en_q[i]),
            .fl_q  (fl_q[i])
         );
      end
   endgenerate

   logic unused_wdata_low;
   assign unused_wdata_low = ^bus_wdata[LOW_W-1:0];

   // ---------------- read path ----------------
   logic [DATA_W-1:0] en_hi_rd, en_lo_rd, fl_hi_rd, fl_lo_rd;

   always_comb begin
      en_hi_rd = '0;
      en_lo_rd = '0;
      fl_hi_rd = '0;
      fl_lo_rd = '0;
      for (int k = 0; k < HALF; k++) begin
         en_hi_rd[DATA_W-1-k] = en_q[k];
         en_lo_rd[DATA_W-1-k] = en_q[HALF+k];
         fl_hi_rd[DATA_W-1-k] = fl_q[k];
         fl_lo_rd[DATA_W-1-k] = fl_q[HALF+k];
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (rhit) begin
         unique case (rsel)
            RSEL_EN_HI: bus_rdata = en_hi_rd;
            RSEL_EN_LO: bus_rdata = en_lo_rd;
            RSEL_FL_HI: bus_rdata = fl_hi_rd;
            RSEL_FL_LO: bus_rdata = fl_lo_rd;
            default:    bus_rdata = '0;
         endcase
      end
   end

   // ---------------- arbitration ----------------
   logic [NSRC-1:0]  pend;
   logic             any_pend;
   logic [IDX_W-1:0] win_idx;

   assign pend = fl_q & en_q;

   irqc_prio_enc #(
      .NSRC      (NSRC),
      .LOW_FIRST (1'b1)
   ) prio_i (
      .pend (pend),
      .any  (any_pend),
      .idx  (win_idx)
   );

   // ---------------- global enable ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gie_o <= 1'b0;
      end else if (ack) begin
         gie_o <= 1'b0;
      end else if (gie_we) begin
         gie_o <= gie_wd;
      end
   end

   assign irq_req = gie_o & any_pend;

   // ---------------- vector capture ----------------
   logic [VEC_W-1:0] vec_next;
   assign vec_next = VEC_TOP - (VEC_W'(win_idx) * VEC_W'(VEC_STEP));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_vec <= '0;
      end else if (ack && irq_req) begin
         irq_vec <= vec_next;
      end
   end
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
   parameter int unsigned NSRC   = 8,
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned VEC_W  = 16,
   parameter logic [ADDR_W-1:0] FL_HI_ADDR = 8'hE4,
   parameter logic [ADDR_W-1:0] FL_LO_ADDR = 8'hE5
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_we,
   input logic [NSRC-1:0]   src_evt,
   input logic              gie_we,
   input logic              gie_wd,
   input logic              gie_o,
   input logic              ack,
   input logic              irq_req,
   input logic [VEC_W-1:0]  irq_vec,
   input logic [NSRC-1:0]   fl_q
);
   logic fl_wr;
   assign fl_wr = bus_we && ((bus_addr == FL_HI_ADDR) || (bus_addr == FL_LO_ADDR));

   a_r5_req_needs_gie: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> gie_o);

   a_r8_ack_clears_gie: assert property (@(posedge clk) disable iff (!rst_n)
      ack |=> !gie_o);

   a_r10_gie_write: assert property (@(posedge clk) disable iff (!rst_n)
      (gie_we && !ack) |=> (gie_o == $past(gie_wd)));

   a_r3_event_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (|src_evt) |=> ((fl_q & $past(src_evt)) == $past(src_evt)));

   a_r9_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !fl_wr |=> ((fl_q & $past(fl_q)) == $past(fl_q)));

   a_r7_vec_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !(ack && irq_req) |=> $stable(irq_vec));
endmodule

bind irq_vec_ctrl irqc_checker #(
   .NSRC       (NSRC),
   .ADDR_W     (ADDR_W),
   .VEC_W      (VEC_W),
   .FL_HI_ADDR (FL_HI_ADDR),
   .FL_LO_ADDR (FL_LO_ADDR)
) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_addr (bus_addr),
   .bus_we   (bus_we),
   .src_evt  (src_evt),
   .gie_we   (gie_we),
   .gie_wd   (gie_wd),
   .gie_o    (gie_o),
   .ack      (ack),
   .irq_req  (irq_req),
   .irq_vec  (irq_vec),
   .fl_q     (fl_q)
);

// File: tb/irq_vec_ctrl_tb_top.sv
module irq_vec_ctrl_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = 8'h00;
   logic        bus_we = 1'b0;
   logic [7:0]  bus_wdata = 8'h00;
   logic [7:0]  bus_rdata;
   logic [7:0]  src_evt = 8'h00;
   logic        gie_we = 1'b0;
   logic        gie_wd = 1'b0;
   logic        gie_o;
   logic        ack = 1'b0;
   logic        irq_req;
   logic [15:0] irq_vec;

   int checks = 0;
   int errors = 0;
   logic [15:0] exp_q[$];
   logic [15:0] last_vec = 16'h0000;
   bit done = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   irq_vec_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_evt(src_evt),
      .gie_we(gie_we), .gie_wd(gie_wd), .gie_o(gie_o), .ack(ack),
      .irq_req(irq_req), .irq_vec(irq_vec)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk); bus_we = 1'b0;
   endtask

   task automatic rd_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
      @(negedge clk); bus_addr = a; #1;
      check(req, {24'h0, bus_rdata}, {24'h0, exp});
   endtask

   task automatic pulse(input logic [7:0] m);
      @(negedge clk); src_evt = m;
      @(negedge clk); src_evt = 8'h00;
   endtask

   task automatic set_gie(input logic v);
      @(negedge clk); gie_we = 1'b1; gie_wd = v;
      @(negedge clk); gie_we = 1'b0;
   endtask

   // driver: pushes the expected vector, then pulses ack for one cycle
   task automatic do_ack(input logic [15:0] exp);
      exp_q.push_back(exp);
      last_vec = exp;
      @(negedge clk); ack = 1'b1;
      @(negedge clk); ack = 1'b0;
   endtask

   // monitor: compares the captured vector after each acknowledge edge
   initial begin
      forever begin
         @(posedge clk);
         if (ack) begin
            @(negedge clk);
            if (exp_q.size() == 0) begin
               check("R7 unexpected ack", 32'h1, 32'h0);
            end else begin
               logic [15:0] e;
               e = exp_q.pop_front();
               check("R7/R6 vector", {16'h0, irq_vec}, {16'h0, e});
            end
         end
      end
   end

   initial begin
      #(4 * 150000);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      rd_chk("R1 en_hi", 8'hE2, 8'h00);
      rd_chk("R1 en_lo", 8'hE3, 8'h00);
      rd_chk("R1 fl_hi", 8'hE4, 8'h00);
      rd_chk("R1 fl_lo", 8'hE5, 8'h00);
      check("R1 gie", {31'h0, gie_o}, 32'h0);
      check("R1 req", {31'h0, irq_req}, 32'h0);
      check("R1 vec", {16'h0, irq_vec}, 32'h0);

      // R2 layout: low nibble ignored
      wr(8'hE2, 8'hF5);
      rd_chk("R2 en_hi low nibble", 8'hE2, 8'hF0);
      wr(8'hE5, 8'h5A);
      rd_chk("R2 fl_lo low nibble", 8'hE5, 8'h50);
      wr(8'hE5, 8'h00);
      rd_chk("R3 flag write 0", 8'hE5, 8'h00);

      // R3 event sets flag (timer 0 -> E4 bit 5)
      pulse(8'h04);
      rd_chk("R3 event T0", 8'hE4, 8'h20);

      // R5 enable but gie off -> no request
      check("R5 no req gie off", {31'h0, irq_req}, 32'h0);
      wr(8'hE2, 8'h00);
      set_gie(1'b1);
      check("R10 gie set", {31'h0, gie_o}, 32'h1);
      check("R5 enable 0 blocks", {31'h0, irq_req}, 32'h0);
      wr(8'hE2, 8'hF0);
      wr(8'hE3, 8'hF0);
      #1 check("R5 req asserted", {31'h0, irq_req}, 32'h1);

      // R6 priority: T0 (idx2) and WDT (idx5) pending
      pulse(8'h20);
      do_ack(16'hFFF6);
      #1 check("R8 gie cleared", {31'h0, gie_o}, 32'h0);
      check("R8 req dropped", {31'h0, irq_req}, 32'h0);
      rd_chk("R9 fl_hi kept", 8'hE4, 8'h20);
      rd_chk("R9 fl_lo kept", 8'hE5, 8'h40);

      // R5/R6 disable timer 0 -> watchdog wins
      wr(8'hE2, 8'hD0);
      set_gie(1'b1);
      do_ack(16'hFFF0);

      // R4 event beats a write of 0 in the same cycle (SPI = E5 bit 4)
      @(negedge clk); bus_addr = 8'hE5; bus_wdata = 8'h00; bus_we = 1'b1; src_evt = 8'h80;
      @(negedge clk); bus_we = 1'b0; src_evt = 8'h00;
      rd_chk("R4 event wins", 8'hE5, 8'h10);

      // R8 ack beats gie write in same cycle; irq_req is 0 so vector holds (R7)
      exp_q.push_back(last_vec);
      @(negedge clk); ack = 1'b1; gie_we = 1'b1; gie_wd = 1'b1;
      @(negedge clk); ack = 1'b0; gie_we = 1'b0;
      #1 check("R8 ack precedence", {31'h0, gie_o}, 32'h0);

      // R7 every vector
      wr(8'hE2, 8'hF0);
      for (int i = 0; i < 8; i++) begin
         wr(8'hE4, 8'h00);
         wr(8'hE5, 8'h00);
         pulse(8'(1 << i));
         set_gie(1'b1);
         do_ack(16'hFFFA - 16'(2 * i));
      end

      repeat (2) @(negedge clk);
      check("R7 queue drained", exp_q.size(), 32'h0);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule